// File: doc/BRIEF.md
# Outstanding Request Tracker With Watchdog

This block sits between a processor-side request port and a cache controller and keeps the books on every memory request that has been sent but not yet answered. Requests are sorted by kind into two small fully associative tables, one for reads and one for writes. Both tables are keyed by line address, which is the request address with its low offset bits dropped. Each new request is either accepted in the cycle it is presented or refused. An accepted request takes a free slot in its table. The slot holds the line, a fresh identifier and the time of issue, taken from a free-running time input.

A completion strobe for the read side or the write side carries a line address. It frees the matching entry of that side's table. One cycle later the block reports the identifier of the freed request and the time it spent outstanding. A timeout watchdog runs alongside the tables. It arms when a request is accepted and looks at the ages of all live entries once per threshold interval, only for as long as anything is outstanding. If any entry has reached the threshold, it raises an alarm that stays up until reset.

Top module: `req_tracker`

## Requirements
- R1: A request is refused whenever the number of outstanding entries has reached MAX_OUT, whichever table it would go to.
- R2: A request is refused when its line (`req_addr >> LINE_OFS`) already has a live entry in either table.
- R3: Kind codes 2 (store), 3 (atomic read half), 4 (atomic write half), 5 (reserving read) and 6 (conditional write) go to the write table. Codes 0 (load), 1 (instruction fetch) and 7 go to the read table. A read completion frees only read-table entries, and a write completion frees only write-table entries.
- R4: A request is refused when its own table has no free slot, even if the total is below MAX_OUT.
- R5: After reset the first accepted request gets identifier 0. Each further acceptance gets the previous identifier plus one, and refusals do not consume identifiers. A completion reports the identifier of the entry it frees.
- R6: A completion is reported in the cycle after its strobe. The reported latency is the time input in the strobe cycle minus the time input in the acceptance cycle. The latency-valid flag is high only when that latency is non-zero.
- R7: A completion whose line has no entry in its own table produces no report and frees nothing.
- R8: The watchdog check falls at the arming time plus THRESH and then every THRESH. The alarm is raised at a check if any live entry's age (now minus issue time) is at least THRESH.
- R9: Once raised, the alarm stays high until reset, even after all entries complete.
- R10: At a check with nothing outstanding, the watchdog disarms. The next accepted request re-arms it with a deadline of that acceptance time plus THRESH.
- R11: The outstanding count always equals the read-table occupancy plus the write-table occupancy. After reset nothing is outstanding, there is no alarm and no completion is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now | input | TIME_W | Free-running time value |
| req_valid | input | 1 | A request is presented |
| req_kind | input | 3 | Request kind code (see R3) |
| req_addr | input | ADDR_W | Request byte address |
| req_accept | output | 1 | Request taken this cycle (combinational) |
| req_id | output | ID_W | Identifier given to a request accepted this cycle |
| rd_done | input | 1 | Read completion strobe |
| rd_line | input | ADDR_W-LINE_OFS | Line address of the read completion |
| wr_done | input | 1 | Write completion strobe |
| wr_line | input | ADDR_W-LINE_OFS | Line address of the write completion |
| rd_cpl_valid | output | 1 | A read entry was freed last cycle |
| rd_cpl_id | output | ID_W | Identifier of the freed read entry |
| rd_cpl_lat | output | TIME_W | Latency of the freed read entry |
| rd_cpl_lat_ok | output | 1 | Read latency is non-zero |
| wr_cpl_valid | output | 1 | A write entry was freed last cycle |
| wr_cpl_id | output | ID_W | Identifier of the freed write entry |
| wr_cpl_lat | output | TIME_W | Latency of the freed write entry |
| wr_cpl_lat_ok | output | 1 | Write latency is non-zero |
| alarm | output | 1 | Sticky timeout alarm |

## Verification
The bench builds the tracker with four slots per table, MAX_OUT of 6, a 16-byte line and THRESH of 40. With these values the total cap can be hit while the write table still has room, and a full read table can be hit while the total is still below the cap. Each case is then reached within a few requests. The short threshold puts several watchdog intervals within a hundred cycles. That is enough to see a stale entry caught only at a later re-armed check, and to see a disarmed watchdog restart from a new acceptance time rather than from its old schedule. The time input can be frozen, so a zero-latency completion can be produced on purpose.

// File: rtl/tracker_pkg.sv
package tracker_pkg;

  typedef enum logic [2:0] {
    K_LOAD   = 3'd0,
    K_IFETCH = 3'd1,
    K_STORE  = 3'd2,
    K_AMO_RD = 3'd3,
    K_AMO_WR = 3'd4,
    K_RSV_RD = 3'd5,
    K_CND_WR = 3'd6,
    K_SPARE  = 3'd7
  } req_kind_e;

  // True when a request kind is tracked in the write table.
  function automatic logic goes_to_write(input logic [2:0] k);
    case (req_kind_e'(k))
      K_STORE, K_AMO_RD, K_AMO_WR, K_RSV_RD, K_CND_WR: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/req_table.sv
module req_table #(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 12,
  parameter int ID_W   = 8,
  parameter int TIME_W = 16,
  parameter int THRESH = 100,
  parameter int OCC_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now,
  input  logic [LINE_W-1:0] probe_line,
  output logic              probe_hit,
  output logic              has_room,
  input  logic              alloc_en,
  input  logic [ID_W-1:0]   alloc_id,
  input  logic              cpl_en,
  input  logic [LINE_W-1:0] cpl_line,
  output logic              cpl_hit,
  output logic [ID_W-1:0]   cpl_id,
  output logic [TIME_W-1:0] cpl_issue,
  output logic [OCC_W-1:0]  occupancy,
  output logic              stale
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  vld;
  logic [LINE_W-1:0] line_q  [DEPTH];
  logic [ID_W-1:0]   id_q    [DEPTH];
  logic [TIME_W-1:0] issue_q [DEPTH];
  logic [IDX_W-1:0]  free_idx;
  logic [IDX_W-1:0]  cpl_idx;

  function automatic logic [TIME_W-1:0] age_of(input logic [TIME_W-1:0] t,
                                               input logic [TIME_W-1:0] t0);
    return t - t0;
  endfunction

  always_comb begin
    probe_hit = 1'b0;
    has_room  = 1'b0;
    cpl_hit   = 1'b0;
    stale     = 1'b0;
    free_idx  = '0;
    cpl_idx   = '0;
    occupancy = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        has_room = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      occupancy = occupancy + OCC_W'(vld[i]);
      if (vld[i] && line_q[i] == probe_line) probe_hit = 1'b1;
      if (vld[i] && line_q[i] == cpl_line) begin
        cpl_hit = 1'b1;
        cpl_idx = IDX_W'(i);
      end
      if (vld[i] && age_of(now, issue_q[i]) >= TIME_W'(THRESH)) stale = 1'b1;
    end
    cpl_id    = id_q[cpl_idx];
    cpl_issue = issue_q[cpl_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      if (cpl_en && cpl_hit) vld[cpl_idx] <= 1'b0;
      if (alloc_en)          vld[free_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      line_q[free_idx]  <= probe_line;
      id_q[free_idx]    <= alloc_id;
      issue_q[free_idx] <= now;
    end
  end

endmodule

// File: rtl/wd_timer.sv
module wd_timer #(
  parameter int TIME_W = 16,
  parameter int THRESH = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now,
  input  logic              arm_req,
  input  logic              busy,
  input  logic              stale_any,
  output logic              armed,
  output logic              fire,
  output logic              alarm
);

  logic [TIME_W-1:0] deadline;

  assign fire = armed && (now == deadline);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      deadline <= '0;
      alarm    <= 1'b0;
    end else begin
      if (fire && stale_any) alarm <= 1'b1;
      if (fire) begin
        if (busy) deadline <= deadline + TIME_W'(THRESH);
        else      armed    <= 1'b0;
      end
      if (arm_req && (!armed || (fire && !busy))) begin
        armed    <= 1'b1;
        deadline <= now + TIME_W'(THRESH);
      end
    end
  end

endmodule

// File: rtl/req_tracker.sv
module req_tracker
  import tracker_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFS = 6,
  parameter int RD_DEPTH = 8,
  parameter int WR_DEPTH = 8,
  parameter int MAX_OUT  = 12,
  parameter int ID_W     = 16,
  parameter int TIME_W   = 32,
  parameter int THRESH   = 5000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [TIME_W-1:0]          now,
  input  logic                       req_valid,
  input  logic [2:0]                 req_kind,
  input  logic [ADDR_W-1:0]          req_addr,
  output logic                       req_accept,
  output logic [ID_W-1:0]            req_id,
  input  logic                       rd_done,
  input  logic [ADDR_W-LINE_OFS-1:0] rd_line,
  input  logic                       wr_done,
  input  logic [ADDR_W-LINE_OFS-1:0] wr_line,
  output logic                       rd_cpl_valid,
  output logic [ID_W-1:0]            rd_cpl_id,
  output logic [TIME_W-1:0]          rd_cpl_lat,
  output logic                       rd_cpl_lat_ok,
  output logic                       wr_cpl_valid,
  output logic [ID_W-1:0]            wr_cpl_id,
  output logic [TIME_W-1:0]          wr_cpl_lat,
  output logic                       wr_cpl_lat_ok,
  output logic                       alarm
);

  localparam int LINE_W   = ADDR_W - LINE_OFS;
  localparam int CNT_W    = $clog2(MAX_OUT + 1);
  localparam int RD_OCC_W = $clog2(RD_DEPTH + 1);
  localparam int WR_OCC_W = $clog2(WR_DEPTH + 1);

  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:LINE_OFS];
  endfunction

  function automatic logic [TIME_W-1:0] latency_of(input logic [TIME_W-1:0] t,
                                                   input logic [TIME_W-1:0] t0);
    return t - t0;
  endfunction

  logic [LINE_W-1:0]   req_line;
  logic                is_wr;
  logic                rd_hit, wr_hit, rd_room, wr_room;
  logic                rd_free, wr_free, rd_cpl_hit, wr_cpl_hit;
  logic [ID_W-1:0]     rd_fid, wr_fid;
  logic [TIME_W-1:0]   rd_fiss, wr_fiss;
  logic [RD_OCC_W-1:0] rd_occ;
  logic [WR_OCC_W-1:0] wr_occ;
  logic                rd_stale, wr_stale;
  logic [CNT_W-1:0]    cnt;
  logic                cap_full, room_ok;
  logic                wd_armed, wd_fire;

  assign req_line   = line_of(req_addr);
  assign is_wr      = goes_to_write(req_kind);
  assign cap_full   = cnt >= CNT_W'(MAX_OUT);
  assign room_ok    = is_wr ? wr_room : rd_room;
  assign req_accept = req_valid && !cap_full && !rd_hit && !wr_hit && room_ok;
  assign rd_free    = rd_done && rd_cpl_hit;
  assign wr_free    = wr_done && wr_cpl_hit;

  req_table #(.DEPTH(RD_DEPTH), .LINE_W(LINE_W), .ID_W(ID_W), .TIME_W(TIME_W),
              .THRESH(THRESH), .OCC_W(RD_OCC_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .now(now),
    .probe_line(req_line), .probe_hit(rd_hit), .has_room(rd_room),
    .alloc_en(req_accept && !is_wr), .alloc_id(req_id),
    .cpl_en(rd_done), .cpl_line(rd_line), .cpl_hit(rd_cpl_hit),
    .cpl_id(rd_fid), .cpl_issue(rd_fiss),
    .occupancy(rd_occ), .stale(rd_stale)
  );

  req_table #(.DEPTH(WR_DEPTH), .LINE_W(LINE_W), .ID_W(ID_W), .TIME_W(TIME_W),
              .THRESH(THRESH), .OCC_W(WR_OCC_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .now(now),
    .probe_line(req_line), .probe_hit(wr_hit), .has_room(wr_room),
    .alloc_en(req_accept && is_wr), .alloc_id(req_id),
    .cpl_en(wr_done), .cpl_line(wr_line), .cpl_hit(wr_cpl_hit),
    .cpl_id(wr_fid), .cpl_issue(wr_fiss),
    .occupancy(wr_occ), .stale(wr_stale)
  );

  wd_timer #(.TIME_W(TIME_W), .THRESH(THRESH)) u_wd (
    .clk(clk), .rst_n(rst_n), .now(now),
    .arm_req(req_accept), .busy(cnt != '0),
    .stale_any(rd_stale || wr_stale),
    .armed(wd_armed), .fire(wd_fire), .alarm(alarm)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      req_id <= '0;
    end else begin
      cnt <= cnt + CNT_W'(req_accept) - CNT_W'(rd_free) - CNT_W'(wr_free);
      if (req_accept) req_id <= req_id + ID_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cpl_valid  <= 1'b0;
      rd_cpl_id     <= '0;
      rd_cpl_lat    <= '0;
      rd_cpl_lat_ok <= 1'b0;
      wr_cpl_valid  <= 1'b0;
      wr_cpl_id     <= '0;
      wr_cpl_lat    <= '0;
      wr_cpl_lat_ok <= 1'b0;
    end else begin
      rd_cpl_valid  <= rd_free;
      rd_cpl_id     <= rd_fid;
      rd_cpl_lat    <= latency_of(now, rd_fiss);
      rd_cpl_lat_ok <= rd_free && (latency_of(now, rd_fiss) != '0);
      wr_cpl_valid  <= wr_free;
      wr_cpl_id     <= wr_fid;
      wr_cpl_lat    <= latency_of(now, wr_fiss);
      wr_cpl_lat_ok <= wr_free && (latency_of(now, wr_fiss) != '0);
    end
  end

endmodule

// File: rtl/tracker_checks.sv
module tracker_checks #(
  parameter int CNT_W    = 4,
  parameter int RD_OCC_W = 3,
  parameter int WR_OCC_W = 3,
  parameter int MAX_OUT  = 6,
  parameter int ID_W     = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_accept,
  input logic [ID_W-1:0]     req_id,
  input logic                rd_hit,
  input logic                wr_hit,
  input logic [CNT_W-1:0]    cnt,
  input logic [RD_OCC_W-1:0] rd_occ,
  input logic [WR_OCC_W-1:0] wr_occ,
  input logic                wd_armed,
  input logic                alarm
);

  assert_count_sum_R11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) == int'(rd_occ) + int'(wr_occ));

  assert_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> int'(cnt) < MAX_OUT);

  assert_no_dup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> !(rd_hit || wr_hit));

  assert_id_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> req_id == $past(req_id) + ID_W'(1));

  assert_alarm_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |=> alarm);

  assert_alarm_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> $past(wd_armed));

  assert_armed_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> wd_armed);

endmodule

bind req_tracker tracker_checks #(
  .CNT_W(CNT_W), .RD_OCC_W(RD_OCC_W), .WR_OCC_W(WR_OCC_W),
  .MAX_OUT(MAX_OUT), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_accept(req_accept), .req_id(req_id),
  .rd_hit(rd_hit), .wr_hit(wr_hit), .cnt(cnt), .rd_occ(rd_occ),
  .wr_occ(wr_occ), .wd_armed(wd_armed), .alarm(alarm)
);

// File: tb/sim_req_tracker.sv
module sim_req_tracker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] now = '0;
  logic        hold = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [15:0] req_addr = '0;
  logic        rd_done = 1'b0, wr_done = 1'b0;
  logic [11:0] rd_line = '0, wr_line = '0;
  logic        req_accept, rd_cpl_valid, rd_cpl_lat_ok, wr_cpl_valid, wr_cpl_lat_ok, alarm;
  logic [7:0]  req_id, rd_cpl_id, wr_cpl_id;
  logic [15:0] rd_cpl_lat, wr_cpl_lat;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] acc_time [16];

  always #4 clk = ~clk;

  req_tracker #(.ADDR_W(16), .LINE_OFS(4), .RD_DEPTH(4), .WR_DEPTH(4), .MAX_OUT(6),
                .ID_W(8), .TIME_W(16), .THRESH(40)) u0 (
    .clk(clk), .rst_n(rst_n), .now(now), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_accept(req_accept), .req_id(req_id),
    .rd_done(rd_done), .rd_line(rd_line), .wr_done(wr_done), .wr_line(wr_line),
    .rd_cpl_valid(rd_cpl_valid), .rd_cpl_id(rd_cpl_id), .rd_cpl_lat(rd_cpl_lat),
    .rd_cpl_lat_ok(rd_cpl_lat_ok), .wr_cpl_valid(wr_cpl_valid), .wr_cpl_id(wr_cpl_id),
    .wr_cpl_lat(wr_cpl_lat), .wr_cpl_lat_ok(wr_cpl_lat_ok), .alarm(alarm)
  );

  // Row: kind[27:25], addr[24:9], expected accept[8], expected id[7:0]
  localparam logic [27:0] VEC [9] = '{
    {3'd0, 16'h0100, 1'b1, 8'd0},
    {3'd0, 16'h0108, 1'b0, 8'd0},
    {3'd2, 16'h0104, 1'b0, 8'd0},
    {3'd2, 16'h0200, 1'b1, 8'd1},
    {3'd1, 16'h0300, 1'b1, 8'd2},
    {3'd0, 16'h0400, 1'b1, 8'd3},
    {3'd3, 16'h0500, 1'b1, 8'd4},
    {3'd0, 16'h0600, 1'b1, 8'd5},
    {3'd2, 16'h0700, 1'b0, 8'd0}
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    if (!hold) now = now + 16'd1;
  endtask

  task automatic drive(input logic v, input logic [2:0] k, input logic [15:0] a,
                       input logic rd, input logic [11:0] rl,
                       input logic wd, input logic [11:0] wl);
    req_valid = v; req_kind = k; req_addr = a;
    rd_done = rd; rd_line = rl; wr_done = wd; wr_line = wl;
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 3'd0, 16'h0, 1'b0, 12'h0, 1'b0, 12'h0);
    tick();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(1'b0, 3'd0, 16'h0, 1'b0, 12'h0, 1'b0, 12'h0);
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic idle_until(input logic [15:0] t);
    while (now != t) idle();
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] t, a0;
    do_reset();

    // R11 reset state
    drive(1'b1, 3'd0, 16'h0900, 1'b0, 12'h0, 1'b0, 12'h0);
    check("R11 reset accept", req_accept, 1);
    check("R5 first id", req_id, 0);
    check("R11 reset alarm", alarm, 0);
    check("R11 reset rd cpl", rd_cpl_valid, 0);
    check("R11 reset wr cpl", wr_cpl_valid, 0);
    do_reset();

    // Table walk: R1 R2 R3 R5
    for (int i = 0; i < 9; i++) begin
      drive(1'b1, VEC[i][27:25], VEC[i][24:9], 1'b0, 12'h0, 1'b0, 12'h0);
      check("R1/R2 accept", req_accept, VEC[i][8]);
      if (VEC[i][8]) begin
        check("R5 id", req_id, VEC[i][7:0]);
        acc_time[VEC[i][3:0]] = now;
      end
      tick();
    end

    // R5 R6 read completion
    t = now;
    drive(1'b0, 3'd0, 16'h0, 1'b1, 12'h010, 1'b0, 12'h0);
    tick();
    check("R6 rd valid", rd_cpl_valid, 1);
    check("R5 rd id", rd_cpl_id, 0);
    check("R6 rd lat", rd_cpl_lat, 32'(t - acc_time[0]));
    check("R6 rd lat ok", rd_cpl_lat_ok, 1);

    // R3 write completion frees store
    t = now;
    drive(1'b0, 3'd0, 16'h0, 1'b0, 12'h0, 1'b1, 12'h020);
    tick();
    check("R3 wr valid", wr_cpl_valid, 1);
    check("R5 wr id", wr_cpl_id, 1);
    check("R6 wr lat", wr_cpl_lat, 32'(t - acc_time[1]));

    // R3 R7 read completion on a write-table line
    drive(1'b0, 3'd0, 16'h0, 1'b1, 12'h050, 1'b0, 12'h0);
    tick();
    check("R7 rd no cpl", rd_cpl_valid, 0);
    drive(1'b1, 3'd0, 16'h0500, 1'b0, 12'h0, 1'b0, 12'h0);
    check("R3 atomic entry kept", req_accept, 0);
    tick();

    // R7 write completion for absent line
    drive(1'b0, 3'd0, 16'h0, 1'b0, 12'h0, 1'b1, 12'h099);
    tick();
    check("R7 wr no cpl", wr_cpl_valid, 0);

    // R2 freed line reusable, R5 id continues
    drive(1'b1, 3'd2, 16'h0100, 1'b0, 12'h0, 1'b0, 12'h0);
    check("R2 reuse accept", req_accept, 1);
    check("R5 id after refusals", req_id, 6);
    tick();

    // R6 zero latency with frozen time
    hold = 1'b1;
    drive(1'b1, 3'd0, 16'h0800, 1'b0, 12'h0, 1'b0, 12'h0);
    check("R6 zl accept", req_accept, 1);
    tick();
    drive(1'b0, 3'd0, 16'h0, 1'b1, 12'h080, 1'b0, 12'h0);
    tick();
    check("R6 zl valid", rd_cpl_valid, 1);
    check("R6 zl lat", rd_cpl_lat, 0);
    check("R6 zl lat ok", rd_cpl_lat_ok, 0);
    hold = 1'b0;

    // R4 table full below the total cap
    do_reset();
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, 3'd0, 16'(16'h1000 + i * 16), 1'b0, 12'h0, 1'b0, 12'h0);
      tick();
    end
    drive(1'b1, 3'd1, 16'h2000, 1'b0, 12'h0, 1'b0, 12'h0);
    check("R4 read table full", req_accept, 0);
    drive(1'b1, 3'd6, 16'h2000, 1'b0, 12'h0, 1'b0, 12'h0);
    check("R4 write table room", req_accept, 1);
    tick();

    // R8 re-arm, R9 sticky
    do_reset();
    a0 = now;
    drive(1'b1, 3'd0, 16'h3000, 1'b0, 12'h0, 1'b0, 12'h0);
    tick();
    idle_until(16'(a0 + 30));
    drive(1'b1, 3'd0, 16'h3100, 1'b0, 12'h0, 1'b0, 12'h0);
    tick();
    idle_until(16'(a0 + 35));
    drive(1'b0, 3'd0, 16'h0, 1'b1, 12'h300, 1'b0, 12'h0);
    tick();
    idle_until(16'(a0 + 41));
    check("R8 young entry no alarm", alarm, 0);
    idle_until(16'(a0 + 80));
    check("R8 before rearmed check", alarm, 0);
    idle();
    check("R8 alarm at rearmed check", alarm, 1);
    drive(1'b0, 3'd0, 16'h0, 1'b1, 12'h310, 1'b0, 12'h0);
    tick();
    for (int i = 0; i < 5; i++) idle();
    check("R9 alarm sticky", alarm, 1);
    do_reset();
    check("R9 reset clears alarm", alarm, 0);

    // R10 disarm then fresh arm
    a0 = now;
    drive(1'b1, 3'd0, 16'h4000, 1'b0, 12'h0, 1'b0, 12'h0);
    tick();
    idle_until(16'(a0 + 5));
    drive(1'b0, 3'd0, 16'h0, 1'b1, 12'h400, 1'b0, 12'h0);
    tick();
    idle_until(16'(a0 + 50));
    drive(1'b1, 3'd0, 16'h4100, 1'b0, 12'h0, 1'b0, 12'h0);
    tick();
    idle_until(16'(a0 + 90));
    check("R10 no alarm before fresh deadline", alarm, 0);
    idle();
    check("R10 alarm at fresh deadline", alarm, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule